// File: doc/BRIEF.md
# Delay-Slot-Aware Fetch PC Sequencer

This block supplies fetch addresses for a multithreaded in-order pipeline whose control instructions are followed by one architectural delay slot. For every hardware thread it keeps three program counters: the address to fetch now, the one after it, and the one after that. When the fetch stage asks for an address on behalf of a thread, the block returns the address together with a per-thread sequence number, then advances that thread's counters by one instruction.

A later stage reports each resolved or predicted control instruction. The block remembers the branch target but redirects fetch only once the delay slot has been handed out. Depending on the kind of control instruction, it also asks the pipeline for a squash. Squash requests arrive on several parallel lanes. When two lanes name the same thread in one cycle, the older request wins. An accepted squash reloads the thread's counters or queues its target behind a delay slot. It also releases a thread that was stalled waiting for a return address. Threads are switched on from an external architectural-state input and switched off by a single strobe.

Top module: `fetch_pc_sequencer`

## Requirements
- R1: A granted fetch returns the thread's current address and sequence number. The following fetch of the same thread returns the address plus `ISZ` (4 bytes by default) and the sequence number plus one. Each thread has its own sequence counter, and the counter starts at 0 after reset.
- R2: A fetch request for a thread that is not valid is not granted. This covers a thread after reset and a thread after deactivation.
- R3: An update for a control instruction predicted taken makes `redir_valid` high in the same cycle, with `redir_seq` equal to the instruction's sequence number plus one and `redir_target` equal to the predicted target. The thread fetches exactly one more sequential address, the delay slot, and then fetches the predicted target.
- R4: An update for an ordinary control instruction predicted not taken raises no squash request. After one delay-slot fetch, the thread fetches the instruction's own next-next address.
- R5: An update for a conditional-delay control instruction predicted not taken raises a squash request with `redir_seq` equal to the instruction's own sequence number and with the predicted target.
- R6: An update whose control flag is low raises no squash request and leaves the thread's fetch addresses unchanged.
- R7: A return predicted not taken marks the thread invalid, so its fetches stall. It sets `stage_block` for the thread and records the reporting stage in `block_stage`. The next accepted squash for that thread pulses `unblock` high in its own cycle, with the recorded stage still shown, and clears the block.
- R8: An accepted squash with `sq_keep_slot` low behaves in one of two ways. If the thread's next sequence number differs from the squash sequence number, the next fetch is the squash target. Otherwise exactly one sequential fetch is made before the squash target.
- R9: An accepted squash with `sq_keep_slot` high makes the next fetch the squash target, and the fetch after it the alternate target.
- R10: Squash lanes are considered in index order, lane 0 first. A lane is accepted unless a lower-index lane for the same thread holds a sequence number less than or equal to its own. The surviving request with the smallest sequence number decides the thread's new state.
- R11: If an accepted squash names the same thread as a fetch request in the same cycle, the fetch is not granted in that cycle.
- R12: Activation loads the thread's three counters from `act_pc`, `act_npc` and `act_nnpc` and makes the thread valid. Deactivation makes the thread invalid and discards any pending branch target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_valid | input | 1 | Activate a thread |
| act_tid | input | TW | Thread to activate |
| act_pc | input | 32 | Current address loaded at activation |
| act_npc | input | 32 | Next address loaded at activation |
| act_nnpc | input | 32 | Next-next address loaded at activation |
| deact_valid | input | 1 | Deactivate a thread |
| deact_tid | input | TW | Thread to deactivate |
| fetch_req | input | 1 | Fetch stage requests an address |
| fetch_tid | input | TW | Thread of the fetch request |
| fetch_grant | output | 1 | Request served this cycle |
| fetch_pc | output | 32 | Address handed out |
| fetch_seq | output | 32 | Sequence number handed out |
| upd_valid | input | 1 | Control-instruction report present |
| upd_tid | input | TW | Thread of the report |
| upd_seq | input | 32 | Sequence number of the reported instruction |
| upd_stage | input | SW | Stage that reports |
| upd_is_ctrl | input | 1 | Instruction is a control instruction |
| upd_is_return | input | 1 | Instruction is a return |
| upd_is_likely | input | 1 | Conditional-delay (annulling) branch |
| upd_pred_taken | input | 1 | Predicted taken |
| upd_pred_target | input | 32 | Predicted target |
| upd_own_nnpc | input | 32 | Instruction's own next-next address |
| redir_valid | output | 1 | Squash request to the pipeline |
| redir_tid | output | TW | Thread to squash |
| redir_seq | output | 32 | Squash everything younger than this |
| redir_target | output | 32 | Address to resume from |
| redir_stage | output | SW | Stage that starts the squash |
| sq_valid | input | NSQ | Squash lane valid |
| sq_tid | input | NSQ*TW | Thread per lane |
| sq_seq | input | NSQ*32 | Sequence number per lane |
| sq_target | input | NSQ*32 | New target per lane |
| sq_keep_slot | input | NSQ | Run the delay slot at the target first |
| sq_alt_target | input | NSQ*32 | Target used after the delay slot when keeping it |
| sq_accept | output | NSQ | Lane accepted |
| stage_block | output | NT | Thread waits for a return address |
| block_stage | output | NT*SW | Stage that blocked, per thread |
| unblock | output | NT | Release pulse, per thread |

## Verification
A wrong delay-slot count or a misplaced target-ready flag shows at the fetch ports. The thread redirects one fetch too early or too late, so the first wrong address appears on the second grant after the control report. A bad triple shift shows on the very next grant as an address that does not step by the instruction size, and a broken sequence counter shows the same way. A lost valid or block flag shows in the same cycle as a grant to a stalled thread, or as a missing unblock pulse when the releasing squash is accepted. A faulty lane filter shows as a wrong acceptance vector, and then as the wrong resume address on the next fetch.

// File: rtl/fps_pkg.sv
// Shared widths and the control-report classification for the fetch
// PC sequencer. Assumes 32-bit addresses and sequence numbers.
package fps_pkg;
    localparam int ADDR_W = 32;
    localparam int SEQ_W  = 32;

    typedef enum logic [2:0] {
        UK_NONE,       // no effect on the thread
        UK_TAKEN,      // predicted taken: target after the delay slot
        UK_FALL,       // ordinary not taken: own next-next after the slot
        UK_ANNUL,      // annulling not taken: squash, no state change here
        UK_RET_WAIT    // return not predicted taken: block until squash
    } upd_kind_e;
endpackage

// File: rtl/fps_ctrl_classify.sv
// Sorts a control-instruction report into one of the update kinds and
// forms the squash request it implies. Purely combinational; assumes
// the report flags are stable while upd_valid is high.
module fps_ctrl_classify
    import fps_pkg::*;
(
    input  logic              upd_valid,
    input  logic              is_ctrl,
    input  logic              is_return,
    input  logic              is_likely,
    input  logic              pred_taken,
    input  logic [SEQ_W-1:0]  seq,
    input  logic [ADDR_W-1:0] pred_target,
    input  logic [ADDR_W-1:0] own_nnpc,
    output upd_kind_e         kind,
    output logic              redir_valid,
    output logic [SEQ_W-1:0]  redir_seq,
    output logic [ADDR_W-1:0] redir_target,
    output logic [ADDR_W-1:0] slot_target
);
    // Pick the report kind; a return test comes before the annul test.
    always_comb begin
        if (!upd_valid || !is_ctrl)         kind = UK_NONE;
        else if (is_return && !pred_taken)  kind = UK_RET_WAIT;
        else if (is_likely && !pred_taken)  kind = UK_ANNUL;
        else if (!pred_taken)               kind = UK_FALL;
        else                                kind = UK_TAKEN;
    end

    // Build the squash request and the target parked behind the slot.
    always_comb begin
        redir_valid  = (kind == UK_TAKEN) || (kind == UK_ANNUL);
        redir_seq    = (kind == UK_TAKEN) ? seq + SEQ_W'(1) : seq;
        redir_target = pred_target;
        slot_target  = (kind == UK_TAKEN) ? pred_target : own_nnpc;
    end
endmodule

// File: rtl/fps_squash_arb.sv
// Filters parallel squash lanes. Lanes are taken in index order and a
// lane is dropped when a lower lane for the same thread already holds an
// equal or smaller sequence number. Reports per thread whether any lane
// survived and which lane carries the oldest (final) request.
module fps_squash_arb
    import fps_pkg::*;
#(
    parameter int NT  = 2,
    parameter int NSQ = 2,
    parameter int TW  = 1,
    parameter int LW  = 1
) (
    input  logic [NSQ-1:0]       sq_valid,
    input  logic [NSQ*TW-1:0]    sq_tid,
    input  logic [NSQ*SEQ_W-1:0] sq_seq,
    output logic [NSQ-1:0]       sq_accept,
    output logic [NT-1:0]        thr_hit,
    output logic [NT*LW-1:0]     thr_win
);
    logic [SEQ_W-1:0] best [NT];

    // Walk lanes in order, keeping the oldest accepted sequence per thread.
    always_comb begin
        sq_accept = '0;
        thr_hit   = '0;
        thr_win   = '0;
        for (int t = 0; t < NT; t++) best[t] = '1;
        for (int i = 0; i < NSQ; i++) begin
            logic [TW-1:0]    tid;
            logic [SEQ_W-1:0] sn;
            tid = sq_tid[i*TW +: TW];
            sn  = sq_seq[i*SEQ_W +: SEQ_W];
            if (sq_valid[i] && int'(tid) < NT) begin
                if (!thr_hit[tid] || sn < best[tid]) begin
                    sq_accept[i]            = 1'b1;
                    thr_hit[tid]            = 1'b1;
                    best[tid]               = sn;
                    thr_win[int'(tid)*LW +: LW] = LW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/fps_thread_ctx.sv
// Per-thread fetch context: address triple, delay-slot counter, parked
// target, valid and block flags, and the sequence counter. Within one
// cycle it applies deactivation, else activation, else fetch then
// control report then squash. Assumes the top never grants a fetch in a
// cycle where this thread is squashed, activated or deactivated.
module fps_thread_ctx
    import fps_pkg::*;
#(
    parameter int ISZ = 4,
    parameter int SW  = 3,
    parameter int CW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_go,
    input  logic [ADDR_W-1:0] act_pc,
    input  logic [ADDR_W-1:0] act_npc,
    input  logic [ADDR_W-1:0] act_nnpc,
    input  logic              deact_go,
    input  logic              fetch_go,
    input  upd_kind_e         upd_kind,
    input  logic [SW-1:0]     upd_stage,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              sq_go,
    input  logic [SEQ_W-1:0]  sq_seq,
    input  logic [ADDR_W-1:0] sq_target,
    input  logic              sq_keep,
    input  logic [ADDR_W-1:0] sq_alt_target,
    output logic              pc_valid,
    output logic              blocked,
    output logic [SW-1:0]     blk_stage,
    output logic [ADDR_W-1:0] cur_pc,
    output logic [SEQ_W-1:0]  seq_next,
    output logic              unblock
);
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(ISZ);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * ISZ);
    localparam logic [ADDR_W-1:0] STEP3 = ADDR_W'(3 * ISZ);

    logic [ADDR_W-1:0] pc_q, npc_q, nnpc_q, tgt_q;
    logic [ADDR_W-1:0] pc_d, npc_d, nnpc_d, tgt_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic              rdy_q, rdy_d, valid_q, valid_d, blk_q, blk_d;
    logic [SW-1:0]     bst_q, bst_d;
    logic [SEQ_W-1:0]  seq_q, seq_d;
    logic              take_tgt;

    // The parked target is used when it is ready and no slot remains.
    always_comb begin
        take_tgt = rdy_q && (cnt_q == '0);
        cur_pc   = take_tgt ? tgt_q : pc_q;
    end

    // Compute the next thread state in the documented priority order.
    always_comb begin
        pc_d = pc_q; npc_d = npc_q; nnpc_d = nnpc_q; tgt_d = tgt_q;
        cnt_d = cnt_q; rdy_d = rdy_q; valid_d = valid_q;
        blk_d = blk_q; bst_d = bst_q; seq_d = seq_q;
        unblock = 1'b0;
        if (deact_go) begin
            cnt_d   = '0;
            rdy_d   = 1'b0;
            valid_d = 1'b0;
            blk_d   = 1'b0;
            bst_d   = '0;
        end else if (act_go) begin
            pc_d    = act_pc;
            npc_d   = act_npc;
            nnpc_d  = act_nnpc;
            valid_d = 1'b1;
        end else begin
            if (fetch_go) begin
                if (take_tgt) begin
                    pc_d   = tgt_q + STEP;
                    npc_d  = tgt_q + STEP2;
                    nnpc_d = tgt_q + STEP3;
                    rdy_d  = 1'b0;
                end else begin
                    pc_d   = npc_q;
                    npc_d  = nnpc_q;
                    nnpc_d = nnpc_q + STEP;
                end
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) rdy_d = 1'b1;
                end
                seq_d = seq_q + SEQ_W'(1);
            end
            case (upd_kind)
                UK_TAKEN, UK_FALL: begin
                    cnt_d = cnt_d + CW'(1);
                    rdy_d = 1'b0;
                    tgt_d = upd_target;
                end
                UK_RET_WAIT: begin
                    valid_d = 1'b0;
                    blk_d   = 1'b1;
                    bst_d   = upd_stage;
                end
                default: ;
            endcase
            if (sq_go) begin
                if (seq_q != sq_seq && !sq_keep) begin
                    cnt_d  = '0;
                    rdy_d  = 1'b0;
                    pc_d   = sq_target;
                    npc_d  = sq_target + STEP;
                    nnpc_d = sq_target + STEP2;
                end else begin
                    cnt_d = CW'(1);
                    rdy_d = 1'b0;
                    tgt_d = sq_keep ? sq_alt_target : sq_target;
                    if (sq_keep) begin
                        pc_d   = sq_target;
                        npc_d  = sq_target + STEP;
                        nnpc_d = sq_target + STEP2;
                    end
                end
                unblock = !valid_q;
                valid_d = 1'b1;
                blk_d   = 1'b0;
            end
        end
    end

    // Register the thread state; reset leaves the thread invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0; npc_q <= '0; nnpc_q <= '0; tgt_q <= '0;
            cnt_q <= '0; rdy_q <= 1'b0; valid_q <= 1'b0;
            blk_q <= 1'b0; bst_q <= '0; seq_q <= '0;
        end else begin
            pc_q <= pc_d; npc_q <= npc_d; nnpc_q <= nnpc_d; tgt_q <= tgt_d;
            cnt_q <= cnt_d; rdy_q <= rdy_d; valid_q <= valid_d;
            blk_q <= blk_d; bst_q <= bst_d; seq_q <= seq_d;
        end
    end

    assign pc_valid  = valid_q;
    assign blocked   = blk_q;
    assign blk_stage = bst_q;
    assign seq_next  = seq_q;
endmodule

// File: rtl/fetch_pc_sequencer.sv
// Top of the fetch PC sequencer. Classifies the control report, filters
// the squash lanes, replicates one context per thread and arbitrates the
// single fetch request against activation, deactivation and squash.
// Assumes at most one activation, one deactivation, one fetch and one
// control report per cycle.
module fetch_pc_sequencer
    import fps_pkg::*;
#(
    parameter int NT  = 2,
    parameter int NSQ = 2,
    parameter int ISZ = 4,
    parameter int SW  = 3,
    parameter int CW  = 4,
    parameter int TW  = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_valid,
    input  logic [TW-1:0]        act_tid,
    input  logic [ADDR_W-1:0]    act_pc,
    input  logic [ADDR_W-1:0]    act_npc,
    input  logic [ADDR_W-1:0]    act_nnpc,
    input  logic                 deact_valid,
    input  logic [TW-1:0]        deact_tid,
    input  logic                 fetch_req,
    input  logic [TW-1:0]        fetch_tid,
    output logic                 fetch_grant,
    output logic [ADDR_W-1:0]    fetch_pc,
    output logic [SEQ_W-1:0]     fetch_seq,
    input  logic                 upd_valid,
    input  logic [TW-1:0]        upd_tid,
    input  logic [SEQ_W-1:0]     upd_seq,
    input  logic [SW-1:0]        upd_stage,
    input  logic                 upd_is_ctrl,
    input  logic                 upd_is_return,
    input  logic                 upd_is_likely,
    input  logic                 upd_pred_taken,
    input  logic [ADDR_W-1:0]    upd_pred_target,
    input  logic [ADDR_W-1:0]    upd_own_nnpc,
    output logic                 redir_valid,
    output logic [TW-1:0]        redir_tid,
    output logic [SEQ_W-1:0]     redir_seq,
    output logic [ADDR_W-1:0]    redir_target,
    output logic [SW-1:0]        redir_stage,
    input  logic [NSQ-1:0]       sq_valid,
    input  logic [NSQ*TW-1:0]    sq_tid,
    input  logic [NSQ*SEQ_W-1:0] sq_seq,
    input  logic [NSQ*ADDR_W-1:0] sq_target,
    input  logic [NSQ-1:0]       sq_keep_slot,
    input  logic [NSQ*ADDR_W-1:0] sq_alt_target,
    output logic [NSQ-1:0]       sq_accept,
    output logic [NT-1:0]        stage_block,
    output logic [NT*SW-1:0]     block_stage,
    output logic [NT-1:0]        unblock
);
    localparam int LW = (NSQ > 1) ? $clog2(NSQ) : 1;

    upd_kind_e         kind;
    logic [ADDR_W-1:0] slot_target;
    logic [NT-1:0]     thr_hit;
    logic [NT*LW-1:0]  thr_win;
    logic [NT-1:0]     valid_v;
    logic [ADDR_W-1:0] curpc_a [NT];
    logic [SEQ_W-1:0]  seq_a   [NT];

    fps_ctrl_classify u_classify (
        .upd_valid    (upd_valid),
        .is_ctrl      (upd_is_ctrl),
        .is_return    (upd_is_return),
        .is_likely    (upd_is_likely),
        .pred_taken   (upd_pred_taken),
        .seq          (upd_seq),
        .pred_target  (upd_pred_target),
        .own_nnpc     (upd_own_nnpc),
        .kind         (kind),
        .redir_valid  (redir_valid),
        .redir_seq    (redir_seq),
        .redir_target (redir_target),
        .slot_target  (slot_target)
    );

    assign redir_tid   = upd_tid;
    assign redir_stage = upd_stage;

    fps_squash_arb #(.NT(NT), .NSQ(NSQ), .TW(TW), .LW(LW)) u_arb (
        .sq_valid  (sq_valid),
        .sq_tid    (sq_tid),
        .sq_seq    (sq_seq),
        .sq_accept (sq_accept),
        .thr_hit   (thr_hit),
        .thr_win   (thr_win)
    );

    // Grant the fetch only to a valid thread with no competing event.
    always_comb begin
        fetch_grant = 1'b0;
        fetch_pc    = '0;
        fetch_seq   = '0;
        if (int'(fetch_tid) < NT) begin
            fetch_pc    = curpc_a[fetch_tid];
            fetch_seq   = seq_a[fetch_tid];
            fetch_grant = fetch_req && valid_v[fetch_tid] && !thr_hit[fetch_tid]
                          && !(act_valid && act_tid == fetch_tid)
                          && !(deact_valid && deact_tid == fetch_tid);
        end
    end

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic [LW-1:0] win;
        upd_kind_e     t_kind;
        assign win    = thr_win[t*LW +: LW];
        assign t_kind = (upd_tid == TW'(t)) ? kind : UK_NONE;

        fps_thread_ctx #(.ISZ(ISZ), .SW(SW), .CW(CW)) u_ctx (
            .clk           (clk),
            .rst_n         (rst_n),
            .act_go        (act_valid && act_tid == TW'(t)),
            .act_pc        (act_pc),
            .act_npc       (act_npc),
            .act_nnpc      (act_nnpc),
            .deact_go      (deact_valid && deact_tid == TW'(t)),
            .fetch_go      (fetch_grant && fetch_tid == TW'(t)),
            .upd_kind      (t_kind),
            .upd_stage     (upd_stage),
            .upd_target    (slot_target),
            .sq_go         (thr_hit[t]),
            .sq_seq        (sq_seq[int'(win)*SEQ_W +: SEQ_W]),
            .sq_target     (sq_target[int'(win)*ADDR_W +: ADDR_W]),
            .sq_keep       (sq_keep_slot[win]),
            .sq_alt_target (sq_alt_target[int'(win)*ADDR_W +: ADDR_W]),
            .pc_valid      (valid_v[t]),
            .blocked       (stage_block[t]),
            .blk_stage     (block_stage[t*SW +: SW]),
            .cur_pc        (curpc_a[t]),
            .seq_next      (seq_a[t]),
            .unblock       (unblock[t])
        );
    end
endmodule

// File: rtl/fps_checker.sv
// Protocol checks for the fetch PC sequencer, attached by bind.
module fps_checker
    import fps_pkg::*;
#(
    parameter int NT  = 2,
    parameter int NSQ = 2,
    parameter int TW  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_req,
    input logic [TW-1:0]     fetch_tid,
    input logic              fetch_grant,
    input logic [SEQ_W-1:0]  fetch_seq,
    input logic              upd_valid,
    input logic              upd_is_ctrl,
    input logic              upd_pred_taken,
    input logic [SEQ_W-1:0]  upd_seq,
    input logic              redir_valid,
    input logic [SEQ_W-1:0]  redir_seq,
    input logic [NSQ-1:0]    sq_valid,
    input logic [NSQ*TW-1:0] sq_tid,
    input logic [NSQ-1:0]    sq_accept,
    input logic [NT-1:0]     stage_block,
    input logic [NT-1:0]     unblock
);
    assert_grant_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_grant |-> fetch_req);

    assert_seq_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fetch_grant) && fetch_grant && fetch_tid == $past(fetch_tid))
        |-> fetch_seq == $past(fetch_seq) + SEQ_W'(1));

    assert_taken_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_is_ctrl && upd_pred_taken)
        |-> (redir_valid && redir_seq == upd_seq + SEQ_W'(1)));

    assert_nonctrl_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_is_ctrl) |-> !redir_valid);

    for (genvar i = 0; i < NSQ; i++) begin : g_lane
        assert_accept_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
            sq_accept[i] |-> sq_valid[i]);
        assert_squash_beats_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (fetch_req && sq_accept[i] && sq_tid[i*TW +: TW] == fetch_tid) |-> !fetch_grant);
    end

    for (genvar t = 0; t < NT; t++) begin : g_thr
        assert_unblock_after_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
            unblock[t] |-> stage_block[t]);
    end
endmodule

bind fetch_pc_sequencer fps_checker #(.NT(NT), .NSQ(NSQ), .TW(TW)) u_fps_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_req      (fetch_req),
    .fetch_tid      (fetch_tid),
    .fetch_grant    (fetch_grant),
    .fetch_seq      (fetch_seq),
    .upd_valid      (upd_valid),
    .upd_is_ctrl    (upd_is_ctrl),
    .upd_pred_taken (upd_pred_taken),
    .upd_seq        (upd_seq),
    .redir_valid    (redir_valid),
    .redir_seq      (redir_seq),
    .sq_valid       (sq_valid),
    .sq_tid         (sq_tid),
    .sq_accept      (sq_accept),
    .stage_block    (stage_block),
    .unblock        (unblock)
);

// File: tb/fetch_pc_sequencer_tb_top.sv
module fetch_pc_sequencer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        act_valid, deact_valid, fetch_req, upd_valid;
    logic [0:0]  act_tid, deact_tid, fetch_tid, upd_tid;
    logic [31:0] act_pc, act_npc, act_nnpc;
    logic        fetch_grant;
    logic [31:0] fetch_pc, fetch_seq;
    logic [31:0] upd_seq, upd_pred_target, upd_own_nnpc;
    logic [2:0]  upd_stage;
    logic        upd_is_ctrl, upd_is_return, upd_is_likely, upd_pred_taken;
    logic        redir_valid;
    logic [0:0]  redir_tid;
    logic [31:0] redir_seq, redir_target;
    logic [2:0]  redir_stage;
    logic [1:0]  sq_valid, sq_keep_slot, sq_accept, sq_tid;
    logic [63:0] sq_seq, sq_target, sq_alt_target;
    logic [1:0]  stage_block, unblock;
    logic [5:0]  block_stage;

    fetch_pc_sequencer dut_i (.*);

    int checks = 0;
    int errs   = 0;
    logic [31:0] exp_pc_q[$];
    logic [31:0] exp_seq_q[$];
    string       exp_tag_q[$];

    task automatic chk(input logic ok, input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    // Monitor: pop the expected item for every granted fetch.
    always @(negedge clk) begin
        if (rst_n && fetch_grant) begin
            if (exp_pc_q.size() == 0) begin
                chk(1'b0, "R1 unexpected grant", fetch_pc, 32'h0);
            end else begin
                string tg;
                logic [31:0] ep, es;
                ep = exp_pc_q.pop_front();
                es = exp_seq_q.pop_front();
                tg = exp_tag_q.pop_front();
                chk(fetch_pc === ep, {tg, " pc"}, fetch_pc, ep);
                chk(fetch_seq === es, {tg, " seq"}, fetch_seq, es);
            end
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
        act_valid = 0; deact_valid = 0; fetch_req = 0; upd_valid = 0;
        act_tid = 0; deact_tid = 0; fetch_tid = 0; upd_tid = 0;
        act_pc = 0; act_npc = 0; act_nnpc = 0;
        upd_seq = 0; upd_pred_target = 0; upd_own_nnpc = 0; upd_stage = 0;
        upd_is_ctrl = 0; upd_is_return = 0; upd_is_likely = 0; upd_pred_taken = 0;
        sq_valid = 0; sq_keep_slot = 0; sq_tid = 0;
        sq_seq = 0; sq_target = 0; sq_alt_target = 0;
    endtask

    // Driver: request a fetch and push the expected result.
    task automatic fetch_exp(input logic [0:0] tid, input logic [31:0] pc, input logic [31:0] sn, input string tag);
        cyc();
        fetch_req = 1; fetch_tid = tid;
        exp_pc_q.push_back(pc); exp_seq_q.push_back(sn); exp_tag_q.push_back(tag);
        @(negedge clk);
        chk(fetch_grant === 1'b1, {tag, " grant"}, 32'(fetch_grant), 32'h1);
    endtask

    task automatic fetch_stall(input logic [0:0] tid, input string tag);
        cyc();
        fetch_req = 1; fetch_tid = tid;
        @(negedge clk);
        chk(fetch_grant === 1'b0, {tag, " stall"}, 32'(fetch_grant), 32'h0);
    endtask

    task automatic activate(input logic [0:0] tid, input logic [31:0] pc);
        cyc();
        act_valid = 1; act_tid = tid; act_pc = pc; act_npc = pc + 4; act_nnpc = pc + 8;
        @(negedge clk);
    endtask

    task automatic deactivate(input logic [0:0] tid);
        cyc();
        deact_valid = 1; deact_tid = tid;
        @(negedge clk);
    endtask

    task automatic report(input logic [0:0] tid, input logic [31:0] sn, input logic [2:0] stg,
                          input logic ctrl, input logic ret, input logic lik, input logic tkn,
                          input logic [31:0] ptarg, input logic [31:0] nnpc,
                          input logic exp_rv, input logic [31:0] exp_rseq, input logic [31:0] exp_rtgt,
                          input string tag);
        cyc();
        upd_valid = 1; upd_tid = tid; upd_seq = sn; upd_stage = stg;
        upd_is_ctrl = ctrl; upd_is_return = ret; upd_is_likely = lik; upd_pred_taken = tkn;
        upd_pred_target = ptarg; upd_own_nnpc = nnpc;
        @(negedge clk);
        chk(redir_valid === exp_rv, {tag, " redir_valid"}, 32'(redir_valid), 32'(exp_rv));
        if (exp_rv) begin
            chk(redir_seq === exp_rseq, {tag, " redir_seq"}, redir_seq, exp_rseq);
            chk(redir_target === exp_rtgt, {tag, " redir_target"}, redir_target, exp_rtgt);
        end
    endtask

    // Drive both squash lanes for thread 0 and check acceptance.
    task automatic squash2(input logic [1:0] v, input logic [31:0] s0, input logic [31:0] t0,
                           input logic [31:0] s1, input logic [31:0] t1,
                           input logic keep0, input logic [31:0] alt0,
                           input logic [1:0] exp_acc, input string tag);
        cyc();
        sq_valid = v; sq_tid = 2'b00; sq_seq = {s1, s0}; sq_target = {t1, t0};
        sq_keep_slot = {1'b0, keep0}; sq_alt_target = {32'h0, alt0};
        @(negedge clk);
        chk(sq_accept === exp_acc, {tag, " accept"}, 32'(sq_accept), 32'(exp_acc));
    endtask

    initial begin
        #(4 * 200000);
        chk(1'b0, "watchdog", 32'h0, 32'h0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        cyc();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(stage_block === 2'b00, "R7 reset block", 32'(stage_block), 32'h0);
        chk(redir_valid === 1'b0, "R6 reset redir", 32'(redir_valid), 32'h0);
        fetch_stall(0, "R2 after reset");

        activate(0, 32'h100);
        fetch_exp(0, 32'h100, 0, "R12 activation");
        fetch_exp(0, 32'h104, 1, "R1 sequential");
        fetch_exp(0, 32'h108, 2, "R1 sequential");

        report(0, 2, 3, 1, 0, 0, 1, 32'h400, 32'h110, 1, 3, 32'h400, "R3 taken");
        squash2(2'b01, 3, 32'h400, 0, 0, 0, 0, 2'b01, "R8 loopback");
        fetch_exp(0, 32'h10C, 3, "R3 delay slot");
        fetch_exp(0, 32'h400, 4, "R3 target");
        fetch_exp(0, 32'h404, 5, "R1 after target");

        report(0, 5, 3, 1, 0, 0, 0, 32'h0, 32'h40C, 0, 0, 0, "R4 not taken");
        fetch_exp(0, 32'h408, 6, "R4 slot");
        fetch_exp(0, 32'h40C, 7, "R4 fallthrough");

        report(0, 7, 2, 1, 0, 1, 0, 32'h414, 32'h414, 1, 7, 32'h414, "R5 annul");
        squash2(2'b01, 7, 32'h414, 0, 0, 0, 0, 2'b01, "R8 reload");
        fetch_exp(0, 32'h414, 8, "R8 reload target");

        report(0, 8, 2, 1, 1, 0, 0, 32'h0, 32'h0, 0, 0, 0, "R7 return");
        @(negedge clk);
        chk(stage_block[0] === 1'b1, "R7 block set", 32'(stage_block[0]), 32'h1);
        chk(block_stage[2:0] === 3'd2, "R7 block stage", 32'(block_stage[2:0]), 32'h2);
        fetch_stall(0, "R7 blocked");
        squash2(2'b01, 9, 32'h800, 0, 0, 0, 0, 2'b01, "R7 release");
        chk(unblock[0] === 1'b1, "R7 unblock pulse", 32'(unblock[0]), 32'h1);
        chk(block_stage[2:0] === 3'd2, "R7 unblock stage", 32'(block_stage[2:0]), 32'h2);
        @(negedge clk);
        chk(stage_block[0] === 1'b0, "R7 block cleared", 32'(stage_block[0]), 32'h0);
        chk(unblock[0] === 1'b0, "R7 pulse ends", 32'(unblock[0]), 32'h0);
        fetch_exp(0, 32'h418, 9, "R8 slot kept");
        fetch_exp(0, 32'h800, 10, "R8 target after slot");

        squash2(2'b11, 20, 32'hA00, 25, 32'hB00, 0, 0, 2'b01, "R10 younger dropped");
        fetch_exp(0, 32'hA00, 11, "R10 older wins");
        squash2(2'b11, 30, 32'hC00, 13, 32'hD00, 0, 0, 2'b11, "R10 older later");
        fetch_exp(0, 32'hD00, 12, "R10 oldest wins");

        cyc();
        fetch_req = 1; fetch_tid = 0;
        sq_valid = 2'b01; sq_seq = {32'h0, 32'd50}; sq_target = {32'h0, 32'hE00};
        @(negedge clk);
        chk(fetch_grant === 1'b0, "R11 squash wins", 32'(fetch_grant), 32'h0);
        fetch_exp(0, 32'hE00, 13, "R11 after squash");

        squash2(2'b01, 60, 32'hF00, 0, 0, 1, 32'h1200, 2'b01, "R9 keep slot");
        fetch_exp(0, 32'hF00, 14, "R9 slot at target");
        fetch_exp(0, 32'h1200, 15, "R9 alternate target");

        report(0, 15, 1, 0, 0, 0, 1, 32'h9990, 32'h9990, 0, 0, 0, "R6 non-control");
        fetch_exp(0, 32'h1204, 16, "R6 unchanged");

        activate(1, 32'h2000);
        fetch_exp(1, 32'h2000, 0, "R1 own counter");
        report(1, 0, 3, 1, 0, 0, 1, 32'h3000, 32'h2008, 1, 1, 32'h3000, "R3 thread1");
        deactivate(1);
        fetch_stall(1, "R2 deactivated");
        activate(1, 32'h5000);
        fetch_exp(1, 32'h5000, 1, "R12 reactivated");
        fetch_exp(1, 32'h5004, 2, "R12 target discarded");

        deactivate(0);
        fetch_stall(0, "R2 thread0 off");

        cyc();
        @(negedge clk);
        chk(exp_pc_q.size() == 0, "R1 scoreboard drained", 32'(exp_pc_q.size()), 32'h0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule